// File: doc/BRIEF.md
# Arbitrated Serial EEPROM Bit-Bang Port

This block is a single control register through which software drives a serial EEPROM one bit at a time. Software sets the chip-select, clock and data-out bits and samples the data-in bit. The EEPROM pins are shared with a memory port, so software must first request ownership by setting the request bit. The block keeps the pins quiet until a grant arrives, and reports the grant through a ready bit.

The ready bit has two jobs. On the first request it only signals that the grant has been taken, with no fixed delay. After that, every register write clears ready, and ready comes back after a fixed settling interval. The interval is a parameter in nanoseconds, turned into a whole number of clock cycles rounded up. Software therefore polls one bit both to wait for ownership and to pace its clock edges. Clearing the request bit gives the pins back to the memory port at once.

Top module: `eeprom_bitbang_port`

## Requirements
- R1: After reset, `rd_data` is 0, `mem_req` and `ee_owned` are low, and `ee_cs`, `ee_sk` and `ee_do` are low.
- R2: A write with bit 5 set raises `mem_req` at the next clock. The grant (`ee_owned`) is taken at the first later clock edge at which `mem_busy` is low, and is withheld at every edge where `mem_busy` is high.
- R3: When the first grant is taken, ready (`rd_data` bit 4) rises in the same cycle as `ee_owned`, with no added delay.
- R4: While owned, `ee_cs`, `ee_sk` and `ee_do` follow the stored register bits 3, 2 and 1. While not owned, all three are held low whatever is stored.
- R5: `rd_data` bit 0 shows `ee_di` while owned, and reads 0 while not owned.
- R6: A write with bit 5 set, made while owned, clears ready for exactly N cycles, where N = ceil(SETTLE_NS*1000 / CLK_PERIOD_PS), with a minimum of 1. A further write during the count restarts the full N.
- R7: A write with bit 5 clear drops `ee_owned`, `mem_req` and ready at the next clock, including in the middle of a settle count.
- R8: `rd_data` bit 5 reads the request state and bits 3 to 1 read the stored pin values, whether or not the port is owned. Bits 7 and 6 always read 0.
- R9: Writes made while waiting for the grant start no settle count, so ready rises together with the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data (bit 5 request, bit 3 select, bit 2 clock, bit 1 data out) |
| rd_data | output | 8 | Register readback (bit 5 request, bit 4 ready, bits 3..1 pins, bit 0 data in) |
| mem_busy | input | 1 | Memory port busy; a grant is taken only when low |
| mem_req | output | 1 | Request to the memory port for the shared pins |
| ee_owned | output | 1 | Pins currently owned by this block |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_do | output | 1 | Data toward the EEPROM |
| ee_di | input | 1 | Data from the EEPROM |

## Verification
The bench holds `mem_busy` high for zero to four cycles after a request. A design that granted one cycle early, or that ignored busy, would show `ee_owned` too soon. It sweeps every pin pattern and data-in value both with and without ownership, which catches pins that leak out before the grant and a data-in bit that is not masked. It counts the ready-low window after a write and restarts the count at every offset inside it, so an off-by-one in the cycle count or a count that is not reloaded shows up. It also checks that writes made while waiting start no count, and that a release in the middle of a count clears ready at once.

// File: rtl/eeprom_port_pkg.sv
package eeprom_port_pkg;

    localparam int BIT_DIN  = 0;
    localparam int BIT_DOUT = 1;
    localparam int BIT_SCLK = 2;
    localparam int BIT_SEL  = 3;
    localparam int BIT_RDY  = 4;
    localparam int BIT_REQ  = 5;

    typedef struct packed {
        logic sel;
        logic sclk;
        logic dout;
    } pin_drive_t;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_WAIT = 2'd1,
        ARB_OWN  = 2'd2
    } arb_state_t;

    function automatic pin_drive_t decode_pins(input logic [7:0] d);
        pin_drive_t p;
        p.sel  = d[BIT_SEL];
        p.sclk = d[BIT_SCLK];
        p.dout = d[BIT_DOUT];
        return p;
    endfunction

    function automatic logic [7:0] pack_status(input logic req, input logic rdy,
                                               input pin_drive_t p, input logic din);
        logic [7:0] s;
        s           = '0;
        s[BIT_REQ]  = req;
        s[BIT_RDY]  = rdy;
        s[BIT_SEL]  = p.sel;
        s[BIT_SCLK] = p.sclk;
        s[BIT_DOUT] = p.dout;
        s[BIT_DIN]  = din;
        return s;
    endfunction

    function automatic int unsigned settle_cycles(input int unsigned period_ps,
                                                  input int unsigned wait_ns);
        int unsigned c;
        c = (wait_ns * 1000 + period_ps - 1) / period_ps;
        if (c == 0) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/eeprom_port_arbiter.sv
module eeprom_port_arbiter
    import eeprom_port_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_set,
    input  logic req_clr,
    input  logic mem_busy,
    output logic mem_req,
    output logic owned
);
    arb_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: if (req_set) state_d = ARB_WAIT;
            ARB_WAIT: begin
                if (req_clr)        state_d = ARB_IDLE;
                else if (!mem_busy) state_d = ARB_OWN;
            end
            ARB_OWN:  if (req_clr) state_d = ARB_IDLE;
            default:  state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ARB_IDLE;
        else     state_q <= state_d;
    end

    assign mem_req = (state_q != ARB_IDLE);
    assign owned   = (state_q == ARB_OWN);
endmodule

// File: rtl/eeprom_settle_timer.sv
module eeprom_settle_timer #(
    parameter int unsigned CYCLES = 80
) (
    input  logic clk,
    input  logic rst,
    input  logic owned,
    input  logic load,
    output logic idle
);
    localparam int TW = $clog2(CYCLES + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !owned)     cnt_q <= '0;
        else if (load)         cnt_q <= TW'(CYCLES);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign idle = (cnt_q == '0);
endmodule

// File: rtl/eeprom_pin_gate.sv
module eeprom_pin_gate
    import eeprom_port_pkg::*;
(
    input  logic       owned,
    input  pin_drive_t drive,
    input  logic       din_pin,
    output pin_drive_t pins,
    output logic       din_seen
);
    assign pins.sel  = owned & drive.sel;
    assign pins.sclk = owned & drive.sclk;
    assign pins.dout = owned & drive.dout;
    assign din_seen  = owned & din_pin;
endmodule

// File: rtl/eeprom_bitbang_port.sv
module eeprom_bitbang_port
    import eeprom_port_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 10000,
    parameter int unsigned SETTLE_NS     = 800
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       mem_busy,
    output logic       mem_req,
    output logic       ee_owned,
    output logic       ee_cs,
    output logic       ee_sk,
    output logic       ee_do,
    input  logic       ee_di
);
    localparam int unsigned SETTLE_CYCLES = settle_cycles(CLK_PERIOD_PS, SETTLE_NS);

    logic       req_set, req_clr, owned, timer_idle, din_seen;
    pin_drive_t drive_q, pins;

    assign req_set = wr_en &  wr_data[BIT_REQ];
    assign req_clr = wr_en & ~wr_data[BIT_REQ];

    always_ff @(posedge clk) begin
        if (rst)        drive_q <= '0;
        else if (wr_en) drive_q <= decode_pins(wr_data);
    end

    eeprom_port_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .req_set  (req_set),
        .req_clr  (req_clr),
        .mem_busy (mem_busy),
        .mem_req  (mem_req),
        .owned    (owned)
    );

    eeprom_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .owned (owned),
        .load  (req_set & owned),
        .idle  (timer_idle)
    );

    eeprom_pin_gate u_gate (
        .owned    (owned),
        .drive    (drive_q),
        .din_pin  (ee_di),
        .pins     (pins),
        .din_seen (din_seen)
    );

    assign ee_owned = owned;
    assign ee_cs    = pins.sel;
    assign ee_sk    = pins.sclk;
    assign ee_do    = pins.dout;
    assign rd_data  = pack_status(mem_req, owned & timer_idle, drive_q, din_seen);
endmodule

// File: rtl/eeprom_port_checker.sv
module eeprom_port_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       mem_busy,
    input logic       mem_req,
    input logic       ee_owned,
    input logic       ee_cs,
    input logic       ee_sk,
    input logic       ee_do
);
    a_r4_pins_idle: assert property (@(posedge clk) disable iff (rst)
        !ee_owned |-> (!ee_cs && !ee_sk && !ee_do));

    a_r5_din_masked: assert property (@(posedge clk) disable iff (rst)
        !ee_owned |-> !rd_data[0]);

    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[5]) |=> (!ee_owned && !mem_req && !rd_data[4]));

    a_r6_write_drops_ready: assert property (@(posedge clk) disable iff (rst)
        (ee_owned && wr_en && wr_data[5]) |=> !rd_data[4]);

    a_r2_grant_withheld: assert property (@(posedge clk) disable iff (rst)
        (!ee_owned && mem_busy) |=> !ee_owned);

    a_r2_grant_taken: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !ee_owned && !mem_busy && !(wr_en && !wr_data[5])) |=> ee_owned);

    a_r3_ready_needs_grant: assert property (@(posedge clk) disable iff (rst)
        rd_data[4] |-> ee_owned);

    a_r3_first_grant_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(ee_owned) |-> rd_data[4]);

    a_r8_high_bits_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:6] == 2'b00);
endmodule

bind eeprom_bitbang_port eeprom_port_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .mem_busy (mem_busy),
    .mem_req  (mem_req),
    .ee_owned (ee_owned),
    .ee_cs    (ee_cs),
    .ee_sk    (ee_sk),
    .ee_do    (ee_do)
);

// File: tb/sim_eeprom_bitbang_port.sv
`timescale 1ns/1ps
module sim_eeprom_bitbang_port;
    localparam int CLK_NS    = 10;
    localparam int PERIOD_PS = CLK_NS * 1000;
    localparam int WAIT_NS   = 45;
    localparam int N_SETTLE  = (WAIT_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       mem_busy = 1'b0;
    logic       mem_req, ee_owned, ee_cs, ee_sk, ee_do;
    logic       ee_di = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_NS/2) clk = ~clk;

    eeprom_bitbang_port #(.CLK_PERIOD_PS(PERIOD_PS), .SETTLE_NS(WAIT_NS)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .mem_busy(mem_busy), .mem_req(mem_req), .ee_owned(ee_owned),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do), .ee_di(ee_di)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic settle();
        repeat (N_SETTLE + 1) @(negedge clk);
    endtask

    task automatic acquire();
        mem_busy = 1'b0;
        wr(8'h20);
        @(negedge clk);
        chk("R2 acquire", ee_owned, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_data", rd_data, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 owned", ee_owned, 0);
        chk("R1 pins", {ee_cs, ee_sk, ee_do}, 0);

        // R4 R5 R8 without ownership
        for (int v = 0; v < 8; v++) begin
            for (int di = 0; di < 2; di++) begin
                ee_di = di[0];
                wr(8'hC0 | 8'(v << 1));
                chk("R4 pins idle", {ee_cs, ee_sk, ee_do}, 0);
                chk("R8 readback unowned", rd_data, 32'(v << 1));
                chk("R5 din masked", rd_data[0], 0);
            end
        end

        // R2 R3 R7 grant latency sweep
        for (int k = 0; k < 5; k++) begin
            mem_busy = (k > 0);
            wr(8'h20);
            chk("R2 req raised", mem_req, 1);
            chk("R2 not yet owned", ee_owned, 0);
            chk("R8 req bit", rd_data[5], 1);
            for (int i = 0; i < k; i++) begin
                @(negedge clk);
                chk("R2 withheld while busy", ee_owned, 0);
            end
            mem_busy = 1'b0;
            @(negedge clk);
            chk("R2 grant taken", ee_owned, 1);
            chk("R3 ready with grant", rd_data[4], 1);
            wr(8'h00);
            chk("R7 owned dropped", ee_owned, 0);
            chk("R7 req dropped", mem_req, 0);
            chk("R7 ready dropped", rd_data[4], 0);
        end

        // R4 R5 R8 with ownership
        acquire();
        for (int v = 0; v < 8; v++) begin
            for (int di = 0; di < 2; di++) begin
                ee_di = di[0];
                wr(8'h20 | 8'(v << 1));
                chk("R4 pins driven", {ee_cs, ee_sk, ee_do}, 32'(v));
                chk("R5 din seen", rd_data[0], 32'(di));
                chk("R8 readback owned", {rd_data[7:5], rd_data[3:1]}, 32'(8 | v));
            end
        end
        ee_di = 1'b0;

        // R6 settle window length
        settle();
        chk("R6 ready before write", rd_data[4], 1);
        wr(8'h28);
        chk("R6 low after write", rd_data[4], 0);
        for (int k = 1; k <= N_SETTLE; k++) begin
            @(negedge clk);
            chk("R6 window", rd_data[4], (k == N_SETTLE) ? 1 : 0);
        end

        // R6 restart at every offset
        for (int m = 1; m < N_SETTLE; m++) begin
            settle();
            wr(8'h20);
            repeat (m - 1) @(negedge clk);
            wr(8'h24);
            chk("R6 restart low", rd_data[4], 0);
            for (int k = 1; k <= N_SETTLE; k++) begin
                @(negedge clk);
                chk("R6 restart window", rd_data[4], (k == N_SETTLE) ? 1 : 0);
            end
        end

        // R7 release mid count
        wr(8'h2C);
        @(negedge clk);
        wr(8'h0C);
        chk("R7 mid-count owned", ee_owned, 0);
        chk("R7 mid-count ready", rd_data[4], 0);
        chk("R7 mid-count pins", {ee_cs, ee_sk, ee_do}, 0);
        chk("R8 stored after release", rd_data, 8'h0C);

        // R9 writes while waiting
        mem_busy = 1'b1;
        wr(8'h20);
        wr(8'h2A);
        wr(8'h2E);
        chk("R9 still waiting", ee_owned, 0);
        mem_busy = 1'b0;
        @(negedge clk);
        chk("R9 owned", ee_owned, 1);
        chk("R9 ready immediate", rd_data[4], 1);
        chk("R9 pins", {ee_cs, ee_sk, ee_do}, 3'b111);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule